// File: doc/BRIEF.md
# Ring Rotator Through Condition Bit

This block rotates a 32-bit operand together with a single condition bit, which acts as a 33rd ring position directly above the operand's most significant bit. A signed amount selects the distance. A positive amount moves bits toward the most significant end. A negative amount moves them toward the least significant end. The bit that leaves the operand becomes the new condition bit, and the previous condition bit enters at the opposite end.

The condition bit is kept in a register inside the block. It can be loaded directly through a write strobe. It changes otherwise only when a rotate is issued. Each issued rotate registers the 32-bit result and the new condition bit. A one-cycle valid pulse marks the result in the following cycle.

Top module: `ring_rot33`

## Requirements
- R1: The ring places the condition bit above operand bit 31. A rotate by +1 moves operand bit 31 into the condition bit and moves the old condition bit into result bit 0.
- R2: A positive amount n (1 to 31) gives `result = (operand << n) | (cc << (n-1)) | (operand >> (33-n))`, with the new condition bit equal to operand bit 32-n.
- R3: A negative amount -m (m from 1 to 32) gives the same outcome as a positive rotation by 33-m around the 33-bit ring. An amount of -32 therefore matches +1.
- R4: An amount of 0 returns the operand unchanged and leaves the condition bit unchanged.
- R5: The result and the new condition bit appear in the cycle after `issue` is sampled high. `res_valid` is high in exactly that cycle and low after any cycle with `issue` low.
- R6: When neither `issue` nor `cc_wr` is high, the condition bit and the result keep their values.
- R7: With `cc_wr` high and `issue` low, the condition bit takes `cc_wdata` in the next cycle. When both are high, the rotate wins and `cc_wdata` is ignored.
- R8: Asserting `rst_n` low clears the condition bit, the result and `res_valid` to 0 at once. Release takes effect after two clock edges.
- R9: A rotate preserves the number of set bits across the 33-bit ring formed by the condition bit and the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Start a rotate with the current operand and amount |
| operand | input | 32 | Data to rotate |
| amount | input | 6 | Signed rotate amount, -32 to +31 |
| cc_wr | input | 1 | Load the condition bit from `cc_wdata` |
| cc_wdata | input | 1 | Value loaded into the condition bit |
| result | output | 32 | Registered rotated data |
| cond_bit | output | 1 | Current condition bit |
| res_valid | output | 1 | High in the cycle after an issued rotate |

## Verification
The assertions take two things for granted. First, `issue`, `cc_wr`, `operand` and `amount` carry known values on every clock edge after reset is released. Second, the amount always lies inside the 6-bit signed range, so the normalized step count never reaches 33. The stimulus drives every input to a defined value from time zero and holds `issue` and `cc_wr` low while reset is asserted. It also sweeps all 64 encodable amounts with both condition-bit values, so no unreachable amount is presented.

// File: rtl/ring_rot_pkg.sv
package ring_rot_pkg;
  localparam int RR_DATA_W = 32;

  typedef enum logic [1:0] {
    ROT_NONE  = 2'd0,
    ROT_LEFT  = 2'd1,
    ROT_RIGHT = 2'd2
  } rot_dir_e;
endpackage

// File: rtl/ring_rst_sync.sv
module ring_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q    <= 1'b0;
      rst_n_out <= 1'b0;
    end else begin
      meta_q    <= 1'b1;
      rst_n_out <= meta_q;
    end
  end
endmodule

// File: rtl/ring_amt_norm.sv
module ring_amt_norm
  import ring_rot_pkg::*;
#(
  parameter int DATA_W = RR_DATA_W,
  parameter int AMT_W  = $clog2(DATA_W) + 1,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic signed [AMT_W-1:0] amt,
  output logic        [CNT_W-1:0] steps
);
  localparam int RING_W = DATA_W + 1;

  rot_dir_e dir;

  always_comb begin
    if (amt == '0)             dir = ROT_NONE;
    else if (amt[AMT_W-1])     dir = ROT_RIGHT;
    else                       dir = ROT_LEFT;
  end

  // a right move by m equals a left move by RING_W - m around the ring
  always_comb begin
    unique case (dir)
      ROT_LEFT:  steps = CNT_W'(amt);
      ROT_RIGHT: steps = CNT_W'(RING_W) + CNT_W'(amt);
      default:   steps = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown(amt)) begin
      assert_steps_in_ring_R3: assert (32'(steps) < RING_W)
        else $error("normalized step count leaves the ring");
    end
  end
endmodule

// File: rtl/ring_rotator.sv
module ring_rotator #(
  parameter int RING_W = 33,
  parameter int CNT_W  = $clog2(RING_W)
) (
  input  logic [RING_W-1:0] ring_in,
  input  logic [CNT_W-1:0]  steps,
  output logic [RING_W-1:0] ring_out
);
  logic [RING_W-1:0] stage [0:CNT_W];

  assign stage[0] = ring_in;

  for (genvar i = 0; i < CNT_W; i++) begin : g_stage
    localparam int SH = (1 << i) % RING_W;
    if (SH == 0) begin : g_pass
      assign stage[i+1] = stage[i];
    end else begin : g_rot
      assign stage[i+1] = steps[i]
                        ? ((stage[i] << SH) | (stage[i] >> (RING_W - SH)))
                        : stage[i];
    end
  end

  assign ring_out = stage[CNT_W];

  always_comb begin
    if (!$isunknown(ring_in) && !$isunknown(steps)) begin
      assert_ring_ones_R9: assert ($countones(ring_out) == $countones(ring_in))
        else $error("ring rotation changed the number of set bits");
    end
  end
endmodule

// File: rtl/ring_rot33.sv
module ring_rot33
  import ring_rot_pkg::*;
#(
  parameter int DATA_W = RR_DATA_W,
  parameter int AMT_W  = $clog2(DATA_W) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue,
  input  logic [DATA_W-1:0]       operand,
  input  logic signed [AMT_W-1:0] amount,
  input  logic                    cc_wr,
  input  logic                    cc_wdata,
  output logic [DATA_W-1:0]       result,
  output logic                    cond_bit,
  output logic                    res_valid
);
  localparam int RING_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(RING_W);

  logic              rst_n_s;
  logic [CNT_W-1:0]  steps;
  logic [RING_W-1:0] ring_rot;

  logic [DATA_W-1:0] res_q, res_d;
  logic              cc_q, cc_d;
  logic              vld_q, vld_d;
  logic              res_en, cc_en;

  ring_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  ring_amt_norm #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W),
    .CNT_W  (CNT_W)
  ) u_norm (
    .amt   (amount),
    .steps (steps)
  );

  ring_rotator #(
    .RING_W (RING_W),
    .CNT_W  (CNT_W)
  ) u_rot (
    .ring_in  ({cc_q, operand}),
    .steps    (steps),
    .ring_out (ring_rot)
  );

  // clock enables
  assign res_en = issue;
  assign cc_en  = issue | cc_wr;

  // next state: a rotate takes priority over a direct condition write
  always_comb begin
    res_d = res_q;
    cc_d  = cc_q;
    vld_d = issue;
    if (issue) begin
      res_d = ring_rot[DATA_W-1:0];
      cc_d  = ring_rot[RING_W-1];
    end else if (cc_wr) begin
      cc_d  = cc_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      res_q <= '0;
      cc_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (res_en) res_q <= res_d;
      if (cc_en)  cc_q  <= cc_d;
    end
  end

  assign result    = res_q;
  assign cond_bit  = cc_q;
  assign res_valid = vld_q;

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    issue |=> res_valid)
    else $error("valid missing after issue");

  assert_valid_low_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !issue |=> !res_valid)
    else $error("valid without issue");

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!issue && !cc_wr) |=> ($stable(cond_bit) && $stable(result)))
    else $error("state moved while idle");

  assert_cc_load_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cc_wr && !issue) |=> (cond_bit == $past(cc_wdata)))
    else $error("condition write lost");

  assert_zero_amount_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (issue && amount == '0) |=> (result == $past(operand) && cond_bit == $past(cond_bit)))
    else $error("zero rotate altered data");

  assert_ones_kept_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    issue |=> ($countones({cond_bit, result}) == $countones({$past(cond_bit), $past(operand)})))
    else $error("set-bit count changed across rotate");
endmodule

// File: tb/sim_ring_rot33.sv
module sim_ring_rot33;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              issue;
  logic [31:0]       operand;
  logic signed [5:0] amount;
  logic              cc_wr;
  logic              cc_wdata;
  logic [31:0]       result;
  logic              cond_bit;
  logic              res_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ring_rot33 u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .operand   (operand),
    .amount    (amount),
    .cc_wr     (cc_wr),
    .cc_wdata  (cc_wdata),
    .result    (result),
    .cond_bit  (cond_bit),
    .res_valid (res_valid)
  );

  // vector: operand, cc in, amount, expected result, expected cc
  localparam int NV = 12;
  localparam logic [71:0] VEC [0:NV-1] = '{
    {32'h80000001, 1'b0, 6'h01, 32'h00000002, 1'b1},
    {32'h80000001, 1'b0, 6'h3F, 32'h40000000, 1'b1},
    {32'h80000001, 1'b0, 6'h1F, 32'hA0000000, 1'b0},
    {32'h80000001, 1'b1, 6'h1F, 32'hE0000000, 1'b0},
    {32'h80000001, 1'b0, 6'h21, 32'h00000005, 1'b0},
    {32'h80000001, 1'b1, 6'h21, 32'h00000007, 1'b0},
    {32'h80000001, 1'b1, 6'h07, 32'h000000E0, 1'b0},
    {32'h80000001, 1'b1, 6'h00, 32'h80000001, 1'b1},
    {32'h80000001, 1'b0, 6'h20, 32'h00000002, 1'b1},
    {32'h00000000, 1'b1, 6'h01, 32'h00000001, 1'b0},
    {32'h00000000, 1'b1, 6'h3F, 32'h80000000, 1'b0},
    {32'hFFFFFFFF, 1'b0, 6'h01, 32'hFFFFFFFE, 1'b1}
  };

  function automatic logic [32:0] ring_ref(input logic [31:0] d, input logic c,
                                           input logic signed [5:0] a);
    logic [32:0] r;
    int n;
    r = {c, d};
    n = (a >= 0) ? int'(a) : 33 + int'(a);
    for (int k = 0; k < n; k++) r = {r[31:0], r[32]};
    return r;
  endfunction

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_rot(input logic [31:0] op, input logic c, input logic signed [5:0] a);
    @(negedge clk);
    cc_wr = 1'b1; cc_wdata = c; issue = 1'b0;
    @(negedge clk);
    cc_wr = 1'b0; issue = 1'b1; operand = op; amount = a;
    @(negedge clk);
    issue = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; issue = 1'b0; cc_wr = 1'b0; cc_wdata = 1'b0;
    operand = '0; amount = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset state", {cond_bit, result}, 33'h0);
    chk("R8 reset valid", {32'h0, res_valid}, 33'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [71:0] e;
      string tg;
      e = VEC[v];
      do_rot(e[71:40], e[39], e[38:33]);
      if ($signed(e[38:33]) == 0)     tg = "R4 vector";
      else if ($signed(e[38:33]) > 0) tg = "R2 vector";
      else                            tg = "R3 vector";
      chk(tg, {cond_bit, result}, {e[0], e[32:1]});
      chk("R5 valid pulse", {32'h0, res_valid}, 33'h1);
    end

    // R1 ring order
    do_rot(32'h80000000, 1'b1, 6'sd1);
    chk("R1 ring order", {cond_bit, result}, {1'b1, 32'h00000001});

    // sweep all amounts, both cc values, random operands
    for (int a = -32; a < 32; a++) begin
      for (int c = 0; c < 2; c++) begin
        logic [31:0] op;
        op = $urandom;
        do_rot(op, c[0], 6'(a));
        chk(a < 0 ? "R3 sweep" : (a == 0 ? "R4 sweep" : "R2 sweep"),
            {cond_bit, result}, ring_ref(op, c[0], 6'(a)));
      end
    end

    // R5 valid drops after one cycle
    @(negedge clk);
    chk("R5 valid low", {32'h0, res_valid}, 33'h0);

    // R6 hold while idle with moving inputs
    begin
      logic [32:0] snap;
      snap = {cond_bit, result};
      operand = 32'h12345678; amount = 6'sd5;
      repeat (3) @(negedge clk);
      chk("R6 idle hold", {cond_bit, result}, snap);
    end

    // R7 direct write without issue
    do_rot(32'h0000FFFF, 1'b0, 6'sd0);
    @(negedge clk); cc_wr = 1'b1; cc_wdata = 1'b1;
    @(negedge clk); cc_wr = 1'b0;
    chk("R7 cc write", {31'h0, cond_bit, res_valid}, {31'h0, 1'b1, 1'b0});
    chk("R7 result kept", {1'b0, result}, {1'b0, 32'h0000FFFF});

    // R7 priority: issue wins over write (cc 0, amount 0 keeps cc 0)
    @(negedge clk); cc_wr = 1'b1; cc_wdata = 1'b0;
    @(negedge clk); cc_wr = 1'b0;
    @(negedge clk); cc_wr = 1'b1; cc_wdata = 1'b1; issue = 1'b1;
    operand = 32'hCAFE0001; amount = 6'sd0;
    @(negedge clk); cc_wr = 1'b0; issue = 1'b0;
    chk("R7 issue priority", {cond_bit, result}, {1'b0, 32'hCAFE0001});

    // R8 mid-run reset is immediate
    do_rot(32'h80000000, 1'b0, 6'sd1);
    rst_n = 1'b0;
    #1;
    chk("R8 async clear", {cond_bit, result}, 33'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); cc_wr = 1'b1; cc_wdata = 1'b1;
    @(negedge clk); cc_wr = 1'b0;
    chk("R8 release delay", {32'h0, cond_bit}, 33'h0);
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule